// File: doc/BRIEF.md
# Timer Compare Output Stage

This block sits behind the 8-bit counter of a timer. It owns one output-compare flip-flop and the logic that decides when that flip-flop is set, cleared or toggled. The inputs are a compare-match pulse, a counter-at-BOTTOM pulse, the counter direction, a 2-bit compare-output setting, a 2-bit waveform-mode setting, a force strobe and an initial-value load port. The same block also chooses whether the port pin is driven from the general-purpose port data bit or from the flip-flop.

The waveform mode is held in a four-state machine. Its states are `WM_NORMAL`, `WM_PHASE`, `WM_CTC` and `WM_FAST`. A configuration write moves it to the state named by `cfg_wgm`; with no write it stays where it is. The flip-flop is a two-state machine, `OC_LOW` and `OC_HIGH`. The edge from `OC_LOW` to `OC_HIGH` is taken on a set or a toggle action. The edge from `OC_HIGH` to `OC_LOW` is taken on a clear or a toggle action. An initial-value load takes either state straight to the loaded level.

The counter, the prescaler, interrupts and register decoding lie outside the block. Their results arrive as plain inputs.

Top module: `tmr_ocout`

## Requirements
- R1: When `com_q` (the last written `cfg_com`) is nonzero, `pin_out` equals `oc_level`; when it is 00, `pin_out` equals `port_data`. This holds in every waveform mode, and a write takes effect on the pin in the cycle after the write.
- R2: `pin_oe` always equals `port_dir`, whatever the compare-output setting.
- R3: A compare-output code of 00 leaves `oc_level` unchanged on a match, a force or a BOTTOM event, in every mode.
- R4: In the non-PWM modes (`cfg_wgm` 00 = normal, 10 = CTC), a sampled `cmp_match` changes `oc_level` at that clock edge: code 01 toggles it, 10 clears it and 11 sets it. A new `cfg_wgm` value governs events from the cycle after the write.
- R5: In the non-PWM modes, `force_cmp` applies the same action as a match, at once. A force and a match in the same cycle give a single action.
- R6: In the PWM modes (01 = phase-correct, 11 = fast), `force_cmp` has no effect on `oc_level`.
- R7: In fast PWM, a match with code 10 clears and with code 11 sets. A BOTTOM pulse with code 10 sets and with code 11 clears. Code 01 does nothing. A match and a BOTTOM pulse in the same cycle take the match action.
- R8: In phase-correct PWM, code 10 clears on a match while counting up (`cnt_down`=0) and sets on a match while counting down. Code 11 does the reverse, and code 01 does nothing. BOTTOM pulses are ignored.
- R9: BOTTOM actions use the code that was in force at the most recent compare match. A newly written code therefore reaches them only after the first match that follows the write.
- R10: `oc_init_we` loads `oc_init_val` into `oc_level` at the next edge, whatever the override state. It wins over any action in the same cycle, so the pin shows a known level once the override is enabled.
- R11: Reset (active-low `rst_n`, asynchronous) clears `oc_level` and the compare-output code to 0 and selects normal mode, so `pin_out` follows `port_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for `cfg_com` and `cfg_wgm` |
| cfg_com | input | 2 | New compare-output code |
| cfg_wgm | input | 2 | New waveform mode |
| cmp_match | input | 1 | Compare-match pulse from the counter |
| cnt_bottom | input | 1 | Counter-at-BOTTOM pulse |
| cnt_down | input | 1 | Counter direction, 1 = counting down |
| force_cmp | input | 1 | Force-compare strobe |
| oc_init_we | input | 1 | Load strobe for the output-compare flip-flop |
| oc_init_val | input | 1 | Level loaded by `oc_init_we` |
| port_data | input | 1 | General-purpose port data bit |
| port_dir | input | 1 | Port direction bit, 1 = output |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Pin output enable |
| oc_level | output | 1 | Current output-compare flip-flop level |

## Verification
The bench first drives directed sequences. It walks each non-PWM code through repeated matches, so toggle can be told apart from set and clear. It issues forces alone and together with a match, which separates a single action from a doubled toggle. It drives fast PWM with BOTTOM pulses before and after a match that follows a code change, which shows that BOTTOM actions use the code latched at the match and not the written one. It drives phase-correct matches in both counting directions, which shows that the direction swaps set and clear. A long phase of sparse random events then mixes mode writes, loads and forces, and every cycle is compared against a behavioural model.

// File: rtl/tmr_ocout_pkg.sv
package tmr_ocout_pkg;

    localparam int COM_W = 2;
    localparam int WGM_W = 2;

    typedef enum logic [WGM_W-1:0] {
        WM_NORMAL = 2'b00,
        WM_PHASE  = 2'b01,
        WM_CTC    = 2'b10,
        WM_FAST   = 2'b11
    } wmode_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TGL  = 2'b11
    } oc_act_e;

    typedef enum logic {
        OC_LOW  = 1'b0,
        OC_HIGH = 1'b1
    } oc_state_e;

    localparam logic [COM_W-1:0] COM_OFF = 2'b00;
    localparam logic [COM_W-1:0] COM_ALT = 2'b01;
    localparam logic [COM_W-1:0] COM_LO  = 2'b10;
    localparam logic [COM_W-1:0] COM_HI  = 2'b11;

    function automatic logic mode_is_pwm(input wmode_e m);
        return (m == WM_PHASE) || (m == WM_FAST);
    endfunction

endpackage

// File: rtl/tmr_ocout_cfg.sv
module tmr_ocout_cfg
    import tmr_ocout_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [COM_W-1:0] cfg_com,
    input  logic [WGM_W-1:0] cfg_wgm,
    input  logic             cmp_match,
    output wmode_e           mode_q,
    output logic [COM_W-1:0] com_q,
    output logic [COM_W-1:0] com_bot_q
);

    wmode_e mode_d;

    // next waveform-mode state
    always_comb begin
        mode_d = mode_q;
        if (cfg_we) begin
            unique case (cfg_wgm)
                2'b00:   mode_d = WM_NORMAL;
                2'b01:   mode_d = WM_PHASE;
                2'b10:   mode_d = WM_CTC;
                default: mode_d = WM_FAST;
            endcase
        end
    end

    // waveform-mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= WM_NORMAL;
        end else begin
            mode_q <= mode_d;
        end
    end

    // written code and the copy captured at each compare match
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            com_q     <= COM_OFF;
            com_bot_q <= COM_OFF;
        end else begin
            if (cmp_match) begin
                com_bot_q <= com_q;
            end
            if (cfg_we) begin
                com_q <= cfg_com;
            end
        end
    end

endmodule

// File: rtl/tmr_ocout_wave.sv
module tmr_ocout_wave
    import tmr_ocout_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  wmode_e           mode_q,
    input  logic [COM_W-1:0] com_q,
    input  logic [COM_W-1:0] com_bot_q,
    input  logic             cmp_match,
    input  logic             cnt_bottom,
    input  logic             cnt_down,
    input  logic             force_cmp,
    input  logic             oc_init_we,
    input  logic             oc_init_val,
    output oc_state_e        oc_q
);

    oc_act_e   match_act;
    oc_act_e   bottom_act;
    oc_act_e   act;
    oc_state_e oc_d;
    logic      fire_match;

    // action for a real or forced compare match
    always_comb begin
        match_act = ACT_NONE;
        unique case (mode_q)
            WM_NORMAL, WM_CTC: begin
                unique case (com_q)
                    COM_ALT: match_act = ACT_TGL;
                    COM_LO:  match_act = ACT_CLR;
                    COM_HI:  match_act = ACT_SET;
                    default: match_act = ACT_NONE;
                endcase
            end
            WM_FAST: begin
                unique case (com_q)
                    COM_LO:  match_act = ACT_CLR;
                    COM_HI:  match_act = ACT_SET;
                    default: match_act = ACT_NONE;
                endcase
            end
            default: begin
                unique case (com_q)
                    COM_LO:  match_act = cnt_down ? ACT_SET : ACT_CLR;
                    COM_HI:  match_act = cnt_down ? ACT_CLR : ACT_SET;
                    default: match_act = ACT_NONE;
                endcase
            end
        endcase
    end

    // action at BOTTOM, fast PWM only, using the code latched at a match
    always_comb begin
        bottom_act = ACT_NONE;
        if (mode_q == WM_FAST) begin
            unique case (com_bot_q)
                COM_LO:  bottom_act = ACT_SET;
                COM_HI:  bottom_act = ACT_CLR;
                default: bottom_act = ACT_NONE;
            endcase
        end
    end

    assign fire_match = cmp_match || (force_cmp && !mode_is_pwm(mode_q));

    always_comb begin
        if (fire_match) begin
            act = match_act;
        end else if (cnt_bottom) begin
            act = bottom_act;
        end else begin
            act = ACT_NONE;
        end
    end

    // next flip-flop state
    always_comb begin
        oc_d = oc_q;
        if (oc_init_we) begin
            oc_d = oc_init_val ? OC_HIGH : OC_LOW;
        end else begin
            unique case (oc_q)
                OC_LOW:  oc_d = (act == ACT_SET || act == ACT_TGL) ? OC_HIGH : OC_LOW;
                default: oc_d = (act == ACT_CLR || act == ACT_TGL) ? OC_LOW : OC_HIGH;
            endcase
        end
    end

    // flip-flop state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oc_q <= OC_LOW;
        end else begin
            oc_q <= oc_d;
        end
    end

endmodule

// File: rtl/tmr_ocout_pinmux.sv
module tmr_ocout_pinmux
    import tmr_ocout_pkg::*;
(
    input  logic [COM_W-1:0] com_q,
    input  logic             oc_bit,
    input  logic             port_data,
    input  logic             port_dir,
    output logic             pin_out,
    output logic             pin_oe
);

    logic ovr;

    assign ovr     = |com_q;
    assign pin_out = ovr ? oc_bit : port_data;
    assign pin_oe  = port_dir;

endmodule

// File: rtl/tmr_ocout.sv
module tmr_ocout
    import tmr_ocout_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_com,
    input  logic [1:0] cfg_wgm,
    input  logic       cmp_match,
    input  logic       cnt_bottom,
    input  logic       cnt_down,
    input  logic       force_cmp,
    input  logic       oc_init_we,
    input  logic       oc_init_val,
    input  logic       port_data,
    input  logic       port_dir,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       oc_level
);

    wmode_e           mode_q;
    logic [COM_W-1:0] com_q;
    logic [COM_W-1:0] com_bot_q;
    logic [WGM_W-1:0] wgm_q;
    oc_state_e        oc_q;

    tmr_ocout_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_com   (cfg_com),
        .cfg_wgm   (cfg_wgm),
        .cmp_match (cmp_match),
        .mode_q    (mode_q),
        .com_q     (com_q),
        .com_bot_q (com_bot_q)
    );

    tmr_ocout_wave u_wave (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_q      (mode_q),
        .com_q       (com_q),
        .com_bot_q   (com_bot_q),
        .cmp_match   (cmp_match),
        .cnt_bottom  (cnt_bottom),
        .cnt_down    (cnt_down),
        .force_cmp   (force_cmp),
        .oc_init_we  (oc_init_we),
        .oc_init_val (oc_init_val),
        .oc_q        (oc_q)
    );

    assign oc_level = (oc_q == OC_HIGH);
    assign wgm_q    = mode_q;

    tmr_ocout_pinmux u_pin (
        .com_q     (com_q),
        .oc_bit    (oc_level),
        .port_data (port_data),
        .port_dir  (port_dir),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

endmodule

// File: rtl/tmr_ocout_chk.sv
module tmr_ocout_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmp_match,
    input logic       cnt_bottom,
    input logic       force_cmp,
    input logic       oc_init_we,
    input logic       oc_init_val,
    input logic       port_data,
    input logic       pin_out,
    input logic       oc_level,
    input logic [1:0] com_q,
    input logic [1:0] com_bot_q,
    input logic [1:0] wgm_q
);

    logic pwm;
    assign pwm = (wgm_q == 2'b01) || (wgm_q == 2'b11);

    AST_PIN_FROM_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (com_q == 2'b00) |-> (pin_out == port_data)); // R1

    AST_PIN_FROM_OC: assert property (@(posedge clk) disable iff (!rst_n)
        (com_q != 2'b00) |-> (pin_out == oc_level)); // R1

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!oc_init_we && com_q == 2'b00 && com_bot_q == 2'b00) |=> (oc_level == $past(oc_level))); // R3

    AST_NONPWM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!oc_init_we && cmp_match && !pwm && com_q == 2'b11) |=> oc_level); // R4

    AST_NONPWM_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!oc_init_we && cmp_match && !pwm && com_q == 2'b01) |=> (oc_level != $past(oc_level))); // R4

    AST_PWM_FORCE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!oc_init_we && !cmp_match && !cnt_bottom && force_cmp && pwm) |=> $stable(oc_level)); // R6

    AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        oc_init_we |=> (oc_level == $past(oc_init_val))); // R10

endmodule

bind tmr_ocout tmr_ocout_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_match   (cmp_match),
    .cnt_bottom  (cnt_bottom),
    .force_cmp   (force_cmp),
    .oc_init_we  (oc_init_we),
    .oc_init_val (oc_init_val),
    .port_data   (port_data),
    .pin_out     (pin_out),
    .oc_level    (oc_level),
    .com_q       (com_q),
    .com_bot_q   (com_bot_q),
    .wgm_q       (wgm_q)
);

// File: tb/tmr_ocout_bench.sv
`timescale 1ns/1ps
module tmr_ocout_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_com = 2'b00;
    logic [1:0] cfg_wgm = 2'b00;
    logic       cmp_match = 1'b0;
    logic       cnt_bottom = 1'b0;
    logic       cnt_down = 1'b0;
    logic       force_cmp = 1'b0;
    logic       oc_init_we = 1'b0;
    logic       oc_init_val = 1'b0;
    logic       port_data = 1'b0;
    logic       port_dir = 1'b0;
    logic       pin_out;
    logic       pin_oe;
    logic       oc_level;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;

    // behavioural model state
    int    m_oc = 0;
    int    m_com = 0;
    int    m_wgm = 0;
    int    m_bot = 0;
    string m_tag = "R11";

    always #4 clk = ~clk;  // 125 MHz

    tmr_ocout u_tmr_ocout (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_com     (cfg_com),
        .cfg_wgm     (cfg_wgm),
        .cmp_match   (cmp_match),
        .cnt_bottom  (cnt_bottom),
        .cnt_down    (cnt_down),
        .force_cmp   (force_cmp),
        .oc_init_we  (oc_init_we),
        .oc_init_val (oc_init_val),
        .port_data   (port_data),
        .port_dir    (port_dir),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .oc_level    (oc_level)
    );

    always @(posedge clk or negedge rst_n) begin : model
        int    nxt;
        int    code;
        bit    pwm;
        string t;
        if (!rst_n) begin
            m_oc = 0; m_com = 0; m_wgm = 0; m_bot = 0; m_tag = "R11";
        end else begin
            nxt = m_oc;
            pwm = (m_wgm == 1) || (m_wgm == 3);
            t = "R3";
            if (oc_init_we) begin
                nxt = oc_init_val; t = "R10";
            end else if (cmp_match || (force_cmp && !pwm)) begin
                code = m_com;
                if (!pwm) begin
                    t = cmp_match ? "R4" : "R5";
                    if (code == 1) nxt = 1 - m_oc;
                    else if (code == 2) nxt = 0;
                    else if (code == 3) nxt = 1;
                end else if (m_wgm == 3) begin
                    t = "R7";
                    if (code == 2) nxt = 0;
                    else if (code == 3) nxt = 1;
                end else begin
                    t = "R8";
                    if (code == 2) nxt = cnt_down ? 1 : 0;
                    else if (code == 3) nxt = cnt_down ? 0 : 1;
                end
                if (code == 0) t = "R3";
            end else if (cnt_bottom && m_wgm == 3) begin
                t = (m_bot != m_com) ? "R9" : "R7";
                if (m_bot == 2) nxt = 1;
                else if (m_bot == 3) nxt = 0;
            end else if (force_cmp) begin
                t = "R6";
            end
            if (cmp_match) m_bot = m_com;
            if (cfg_we) begin m_com = cfg_com; m_wgm = cfg_wgm; end
            m_oc = nxt;
            m_tag = t;
        end
    end

    task automatic chk(input logic act, input logic exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic exp_pin;
        exp_pin = (m_com != 0) ? logic'(m_oc[0]) : port_data;
        chk(pin_out, exp_pin, (m_com != 0) ? "R1 pin from flip-flop" : "R1 pin from port");
        chk(pin_oe, port_dir, "R2");
        chk(oc_level, logic'(m_oc[0]), m_tag);
    endtask

    task automatic idle_in();
        cfg_we = 0; cmp_match = 0; cnt_bottom = 0; force_cmp = 0; oc_init_we = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        check_all();
        idle_in();
    endtask

    task automatic cfg(input logic [1:0] c, input logic [1:0] w);
        cfg_we = 1; cfg_com = c; cfg_wgm = w; tick();
    endtask

    task automatic match(input logic down);
        cmp_match = 1; cnt_down = down; tick();
    endtask

    task automatic bottom();
        cnt_bottom = 1; tick();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin : main
        // R11: reset state with port data high
        port_data = 1; port_dir = 1;
        repeat (3) begin @(negedge clk); check_all(); end
        rst_n = 1;
        tick();

        // R3 / R1: code 00 in normal mode, port passes through
        repeat (2) match(0);
        port_data = 0; tick();
        force_cmp = 1; tick();

        // R4: normal mode, toggle / clear / set
        cfg(2'b01, 2'b00);
        repeat (3) match(0);
        cfg(2'b10, 2'b00);
        match(0); match(0);
        cfg(2'b11, 2'b00);
        match(0); bottom();

        // R4 / R5: CTC toggle, force alone, force with match
        cfg(2'b01, 2'b10);
        match(0);
        force_cmp = 1; tick();
        force_cmp = 1; cmp_match = 1; tick();
        cfg(2'b10, 2'b10);
        force_cmp = 1; tick();

        // R7 / R9 / R6: fast PWM
        cfg(2'b10, 2'b11);
        bottom();                // latched code still from CTC phase
        match(0);                // code 10 clears, latches 10
        bottom();                // sets
        force_cmp = 1; tick();   // ignored
        cmp_match = 1; cnt_bottom = 1; tick();
        cfg(2'b11, 2'b11);
        bottom();                // still uses 10
        match(0);                // sets, latches 11
        bottom();                // clears
        cfg(2'b01, 2'b11);
        match(0); bottom(); bottom();

        // R8 / R6: phase-correct
        cfg(2'b10, 2'b01);
        match(0); match(1); match(0); bottom();
        force_cmp = 1; tick();
        cfg(2'b11, 2'b01);
        match(0); match(1); match(1);
        cfg(2'b01, 2'b01);
        match(0);

        // R10: initialise while override is off, then enable
        cfg(2'b00, 2'b00);
        oc_init_we = 1; oc_init_val = 1; port_data = 0; tick();
        tick();
        cfg(2'b11, 2'b10);
        tick();
        oc_init_we = 1; oc_init_val = 0; cmp_match = 1; tick();
        port_dir = 0; tick();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            cfg_we      = ($urandom_range(0, 15) == 0);
            cfg_com     = 2'($urandom_range(0, 3));
            cfg_wgm     = 2'($urandom_range(0, 3));
            cmp_match   = ($urandom_range(0, 3) == 0);
            cnt_bottom  = ($urandom_range(0, 3) == 0);
            cnt_down    = 1'($urandom_range(0, 1));
            force_cmp   = ($urandom_range(0, 7) == 0);
            oc_init_we  = ($urandom_range(0, 19) == 0);
            oc_init_val = 1'($urandom_range(0, 1));
            port_data   = 1'($urandom_range(0, 1));
            port_dir    = 1'($urandom_range(0, 1));
            tick();
        end

        done = 1;
        summary();
        $finish;
    end

endmodule